// File: doc/BRIEF.md
# SONET Serial Frame Aligner

This block takes a serial SONET/SDH bit stream, one bit per bit clock, and finds the byte boundary from the framing bytes at the start of each frame. It looks at every bit offset for three consecutive A1 bytes (8'hF6) followed at once by three A2 bytes (8'h28), compared MSB first. When the pattern completes, the block moves its byte boundary onto it. From then on it delivers byte-aligned parallel data, starting with the third A2 byte, and it marks that byte with a frame pulse.

Hunting is controlled by a level-sensitive out-of-frame request. While the request is high, the block keeps searching and realigns on every complete framing pattern it finds, including patterns after the first. A pattern whose three A1 bytes completed while the request was still high may finish after the request falls, and it is still honoured. Otherwise, with the request low, the byte boundary stays where it is. A one-bit-clock strobe marks each new output byte and stands in for the divided byte clock.

Top module: `sonet_frame_aligner`

## Requirements
- R1: On reset, `byte_out`, `byte_stb` and `frame_pulse` are all 0 and the alignment offset is zero. The first strobe appears on the 8th bit clock after reset is released, and there is no frame pulse until the first detection.
- R2: `byte_stb` is high for one bit clock every 8 bit clocks unless the block realigns. Each strobed byte holds the 8 most recently received bits, with the earliest of them in bit 7.
- R3: Detection needs three consecutive 8'hF6 bytes followed immediately by three 8'h28 bytes, at any bit offset. Two A1 bytes, or a third A2-position byte of any other value, produce no frame.
- R4: When a frame is detected, `byte_out` shows 8'h28 with `byte_stb` and `frame_pulse` high, 1 bit clock after the last bit of the third A2 byte was sampled. The following bytes are strobed at +9, +17, … bit clocks from that last bit.
- R5: `frame_pulse` lasts exactly one byte period and falls at the next strobe. `byte_out` and `frame_pulse` change only on a strobe.
- R6: While `oof` is high, a later framing pattern at a different bit offset realigns the output again and raises a new frame pulse.
- R7: While `oof` is low and no detection is pending, a framing pattern is ignored: there is no frame pulse and the strobe spacing and byte boundary are unchanged.
- R8: A detection is pending when `oof` is high on the bit clock that samples the first bit after the third A1 byte. Such a frame completes even if `oof` falls during the A2 bytes. If `oof` falls before that point, no frame results. Raising `oof` 32 bit clocks before the A1/A2 boundary is therefore enough to capture that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset, bit-clock domain |
| serial_in | input | 1 | Serial data bit, sampled on the rising edge |
| oof | input | 1 | Level-sensitive out-of-frame request, enables hunting |
| byte_out | output | 8 | Aligned parallel byte, first received bit in bit 7 |
| byte_stb | output | 1 | One-bit-clock strobe marking a new byte |
| frame_pulse | output | 1 | High for the byte period of the third A2 byte |

## Verification
Each result has a fixed latency, counted in bit clocks from the sampling edge of a given input bit:
- The realigned byte carrying the frame pulse is due one bit clock after the edge that samples the last bit of the third A2 byte.
- Every later byte is due eight bit clocks after the previous one.
- A pending detection depends on `oof` at the edge one bit after the third A1 byte.

The bench numbers every sampling edge since reset and samples the outputs one time unit after each edge. It records each strobed byte with its edge number and compares that number with the values listed above. For every strobed byte, it rebuilds the expected contents from its own history of sent bits, taking the eight bits before that edge.

// File: rtl/sfa_pkg.sv
`timescale 1ns/1ps
package sfa_pkg;

    localparam int unsigned SFA_BYTE_W = 8;
    localparam int unsigned SFA_N_A1   = 3;
    localparam int unsigned SFA_N_A2   = 3;
    localparam logic [SFA_BYTE_W-1:0] SFA_A1 = 8'hF6;
    localparam logic [SFA_BYTE_W-1:0] SFA_A2 = 8'h28;

    // Result of the pattern comparators on the search window.
    typedef struct packed {
        logic full;     // whole A1..A2 pattern in the window
        logic a1_run;   // newest bytes form the complete A1 run
    } sfa_hit_t;

    // Hunting permission seen by the realignment logic.
    typedef enum logic [1:0] {
        MODE_FROZEN = 2'd0,
        MODE_OPEN   = 2'd1,
        MODE_ARMED  = 2'd2
    } sfa_mode_e;

    // Bits still to come after the A1 run completes.
    function automatic int unsigned sfa_arm_len(input int unsigned byte_w,
                                                input int unsigned n_a2);
        return byte_w * n_a2;
    endfunction

endpackage

// File: rtl/sfa_shifter.sv
`timescale 1ns/1ps
module sfa_shifter
    import sfa_pkg::*;
#(
    parameter int unsigned BYTE_W = SFA_BYTE_W,
    parameter int unsigned N_A1   = SFA_N_A1,
    parameter int unsigned N_A2   = SFA_N_A2,
    parameter logic [BYTE_W-1:0] A1_VAL = SFA_A1,
    parameter logic [BYTE_W-1:0] A2_VAL = SFA_A2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] low_byte,
    output sfa_hit_t          hit
);
    localparam int unsigned N_LANES = N_A1 + N_A2;
    localparam int unsigned WIN_W   = BYTE_W * N_LANES;

    logic [WIN_W-1:0]   win_q;
    logic [N_LANES-1:0] pat_ok;
    logic [N_A1-1:0]    run_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= {win_q[WIN_W-2:0], bit_in};
        end
    end

    // Lane 0 holds the newest byte: A2 lanes low, A1 lanes above them.
    for (genvar j = 0; j < N_LANES; j++) begin : g_pat
        localparam logic [BYTE_W-1:0] EXP = (j < N_A2) ? A2_VAL : A1_VAL;
        assign pat_ok[j] = (win_q[j*BYTE_W +: BYTE_W] == EXP);
    end

    for (genvar j = 0; j < N_A1; j++) begin : g_run
        assign run_ok[j] = (win_q[j*BYTE_W +: BYTE_W] == A1_VAL);
    end

    always_comb begin
        hit.full   = &pat_ok;
        hit.a1_run = &run_ok;
    end

    assign low_byte = win_q[BYTE_W-1:0];

endmodule

// File: rtl/sfa_hunt_ctl.sv
`timescale 1ns/1ps
module sfa_hunt_ctl
    import sfa_pkg::*;
#(
    parameter int unsigned BYTE_W = SFA_BYTE_W,
    parameter int unsigned N_A2   = SFA_N_A2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     oof,
    input  sfa_hit_t hit,
    output logic     realign,
    output logic     armed
);
    localparam int unsigned ARM_LEN = sfa_arm_len(BYTE_W, N_A2);
    localparam int unsigned ARM_W   = $clog2(ARM_LEN + 1);

    logic [ARM_W-1:0] arm_q;
    sfa_mode_e        mode;

    assign armed = (arm_q != '0);

    always_comb begin
        if (oof)        mode = MODE_OPEN;
        else if (armed) mode = MODE_ARMED;
        else            mode = MODE_FROZEN;
    end

    assign realign = hit.full && (mode != MODE_FROZEN);

    // Window that lets a frame started under oof finish after oof drops.
    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= '0;
        end else if (realign) begin
            arm_q <= '0;
        end else if (oof && hit.a1_run) begin
            arm_q <= ARM_W'(ARM_LEN);
        end else if (armed) begin
            arm_q <= arm_q - 1'b1;
        end
    end

endmodule

// File: rtl/sfa_byte_phase.sv
`timescale 1ns/1ps
module sfa_byte_phase
    import sfa_pkg::*;
#(
    parameter int unsigned BYTE_W = SFA_BYTE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic realign,
    output logic capture
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0] cnt_q;

    assign capture = realign || (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (capture) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sfa_out_reg.sv
`timescale 1ns/1ps
module sfa_out_reg
    import sfa_pkg::*;
#(
    parameter int unsigned BYTE_W = SFA_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              realign,
    input  logic [BYTE_W-1:0] low_byte,
    output logic [BYTE_W-1:0] data_q,
    output logic              stb_q,
    output logic              fp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            stb_q  <= 1'b0;
            fp_q   <= 1'b0;
        end else begin
            stb_q <= capture;
            if (capture) begin
                data_q <= low_byte;
                fp_q   <= realign;
            end
        end
    end

endmodule

// File: rtl/sonet_frame_aligner.sv
`timescale 1ns/1ps
module sonet_frame_aligner
    import sfa_pkg::*;
#(
    parameter int unsigned BYTE_W = SFA_BYTE_W,
    parameter int unsigned N_A1   = SFA_N_A1,
    parameter int unsigned N_A2   = SFA_N_A2,
    parameter logic [BYTE_W-1:0] A1_VAL = SFA_A1,
    parameter logic [BYTE_W-1:0] A2_VAL = SFA_A2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_in,
    input  logic              oof,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_stb,
    output logic              frame_pulse
);
    sfa_hit_t          hit;
    logic [BYTE_W-1:0] low_byte;
    logic              realign;
    logic              armed;
    logic              capture;

    sfa_shifter #(
        .BYTE_W (BYTE_W),
        .N_A1   (N_A1),
        .N_A2   (N_A2),
        .A1_VAL (A1_VAL),
        .A2_VAL (A2_VAL)
    ) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (serial_in),
        .low_byte (low_byte),
        .hit      (hit)
    );

    sfa_hunt_ctl #(
        .BYTE_W (BYTE_W),
        .N_A2   (N_A2)
    ) u_hunt (
        .clk     (clk),
        .rst     (rst),
        .oof     (oof),
        .hit     (hit),
        .realign (realign),
        .armed   (armed)
    );

    sfa_byte_phase #(
        .BYTE_W (BYTE_W)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .realign (realign),
        .capture (capture)
    );

    sfa_out_reg #(
        .BYTE_W (BYTE_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .realign  (realign),
        .low_byte (low_byte),
        .data_q   (byte_out),
        .stb_q    (byte_stb),
        .fp_q     (frame_pulse)
    );

endmodule

// File: rtl/sfa_checker.sv
`timescale 1ns/1ps
module sfa_checker
    import sfa_pkg::*;
#(
    parameter int unsigned BYTE_W = SFA_BYTE_W,
    parameter logic [BYTE_W-1:0] A2_VAL = SFA_A2
) (
    input logic              clk,
    input logic              rst,
    input logic              oof,
    input logic              armed,
    input logic [BYTE_W-1:0] byte_out,
    input logic              byte_stb,
    input logic              frame_pulse
);
    localparam int unsigned GAP_W = $clog2(BYTE_W) + 2;

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)                  gap_q <= '0;
        else if (byte_stb)        gap_q <= '0;
        else if (gap_q != '1)     gap_q <= gap_q + 1'b1;
    end

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!frame_pulse && !byte_stb && byte_out == '0)); // R1

    AST_STB_GAP: assert property (@(posedge clk) disable iff (rst)
        (32'(gap_q) >= BYTE_W) |-> byte_stb); // R2

    AST_FP_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_pulse) |-> (byte_stb && byte_out == A2_VAL)); // R4

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !byte_stb |-> ($stable(byte_out) && $stable(frame_pulse))); // R5

    AST_HUNT_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_pulse) |-> ($past(oof) || $past(armed))); // R7

endmodule

bind sonet_frame_aligner sfa_checker #(
    .BYTE_W (BYTE_W),
    .A2_VAL (A2_VAL)
) u_sfa_checker (
    .clk         (clk),
    .rst         (rst),
    .oof         (oof),
    .armed       (armed),
    .byte_out    (byte_out),
    .byte_stb    (byte_stb),
    .frame_pulse (frame_pulse)
);

// File: tb/sonet_frame_aligner_bench.sv
`timescale 1ns/1ps
module sonet_frame_aligner_bench;

    localparam logic [7:0] A1 = 8'hF6;
    localparam logic [7:0] A2 = 8'h28;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       serial_in = 1'b0;
    logic       oof = 1'b0;
    logic [7:0] byte_out;
    logic       byte_stb;
    logic       frame_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int nb = 0;
    int ncap = 0;
    int hold_bad = 0;
    bit         hist  [0:4095];
    logic [7:0] cap_b [0:1023];
    bit         cap_f [0:1023];
    int         cap_t [0:1023];
    logic [7:0] last_b;
    logic       last_f;

    always #2 clk = ~clk;

    sonet_frame_aligner u_sonet_frame_aligner (
        .clk         (clk),
        .rst         (rst),
        .serial_in   (serial_in),
        .oof         (oof),
        .byte_out    (byte_out),
        .byte_stb    (byte_stb),
        .frame_pulse (frame_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; serial_in = 1'b0; oof = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        nb = 0; ncap = 0; hold_bad = 0;
        hist[0] = 1'b0;
        last_b = byte_out;
        last_f = frame_pulse;
    endtask

    task automatic send_bit(input bit b, input bit o);
        serial_in = b;
        oof = o;
        @(posedge clk);
        #1;
        nb++;
        hist[nb] = b;
        if (byte_stb) begin
            cap_b[ncap] = byte_out;
            cap_f[ncap] = frame_pulse;
            cap_t[ncap] = nb;
            ncap++;
        end else if (byte_out !== last_b || frame_pulse !== last_f) begin
            hold_bad++;
        end
        last_b = byte_out;
        last_f = frame_pulse;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit o);
        for (int k = 7; k >= 0; k--) send_bit(v[k], o);
    endtask

    task automatic send_frame(input bit o);
        for (int k = 0; k < 3; k++) send_byte(A1, o);
        for (int k = 0; k < 3; k++) send_byte(A2, o);
    endtask

    function automatic logic [7:0] win(input int t);
        logic [7:0] w;
        for (int k = 0; k < 8; k++) w[7-k] = hist[t-8+k];
        return w;
    endfunction

    function automatic int count_fp(input int from);
        int c = 0;
        for (int i = from; i < ncap; i++) if (cap_f[i]) c++;
        return c;
    endfunction

    function automatic int nth_fp(input int n);
        int c = 0;
        for (int i = 0; i < ncap; i++) begin
            if (cap_f[i]) begin
                if (c == n) return i;
                c++;
            end
        end
        return -1;
    endfunction

    task automatic check_bytes(input string req);
        int bad = 0;
        int fa = 0;
        int fe = 0;
        for (int i = 0; i < ncap; i++) begin
            if (cap_b[i] !== win(cap_t[i])) begin
                if (bad == 0) begin fa = int'(cap_b[i]); fe = int'(win(cap_t[i])); end
                bad++;
            end
        end
        chk(bad == 0, req, fa, fe);
    endtask

    // R1 reset state, R2 strobe spacing and bit order
    task automatic t_reset();
        do_reset();
        chk(byte_out == 8'h00, "R1 byte_out after reset", int'(byte_out), 0);
        chk(frame_pulse == 1'b0, "R1 frame_pulse after reset", int'(frame_pulse), 0);
        chk(byte_stb == 1'b0, "R1 byte_stb after reset", int'(byte_stb), 0);
        send_byte(8'hA5, 1'b0);
        send_byte(8'h3C, 1'b0);
        send_byte(8'hC3, 1'b0);
        chk(ncap == 3, "R2 strobe count", ncap, 3);
        chk(cap_t[0] == 8, "R1 first strobe time", cap_t[0], 8);
        chk(cap_t[2] - cap_t[1] == 8, "R2 strobe spacing", cap_t[2] - cap_t[1], 8);
        check_bytes("R2 byte contents");
        chk(count_fp(0) == 0, "R1 no pulse before detection", count_fp(0), 0);
    endtask

    // R3 any offset, R4 timing/value, R5 width, R8 oof 32 bits ahead
    task automatic t_offsets();
        for (int lead = 0; lead < 8; lead++) begin
            int last;
            int idx;
            do_reset();
            for (int k = 0; k < lead; k++) send_bit(k[0], 1'b0);
            send_byte(8'h0F, 1'b0);
            send_byte(8'h55, 1'b1);
            send_frame(1'b1);
            last = nb;
            send_byte(8'h11, 1'b1);
            send_byte(8'h22, 1'b1);
            send_byte(8'h33, 1'b1);
            idx = nth_fp(0);
            chk(idx >= 0, "R8 frame captured with oof 32 bits early", idx, 0);
            chk(count_fp(0) == 1, "R3 one frame per pattern", count_fp(0), 1);
            if (idx >= 0) begin
                chk(cap_t[idx] == last + 1, "R4 pulse timing", cap_t[idx], last + 1);
                chk(cap_b[idx] == A2, "R4 aligned byte is A2", int'(cap_b[idx]), int'(A2));
                chk(idx + 1 < ncap && cap_t[idx+1] == last + 9 && !cap_f[idx+1],
                    "R5 pulse ends at next strobe", (idx + 1 < ncap) ? cap_t[idx+1] : -1, last + 9);
            end
            check_bytes("R2 bytes around realign");
            chk(hold_bad == 0, "R5 outputs change only on strobe", hold_bad, 0);
        end
    endtask

    // R3 near misses give no frame
    task automatic t_near_miss();
        do_reset();
        send_byte(8'h00, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(A1, 1'b1); send_byte(A1, 1'b1);
        send_byte(A2, 1'b1); send_byte(A2, 1'b1); send_byte(A2, 1'b1);
        send_byte(8'h00, 1'b1);
        chk(count_fp(0) == 0, "R3 two A1 bytes rejected", count_fp(0), 0);
        send_byte(A1, 1'b1); send_byte(A1, 1'b1); send_byte(A1, 1'b1);
        send_byte(A2, 1'b1); send_byte(A2, 1'b1); send_byte(8'h29, 1'b1);
        send_byte(8'h00, 1'b1);
        chk(count_fp(0) == 0, "R3 wrong third A2 rejected", count_fp(0), 0);
    endtask

    // R6 repeated hunting while oof high
    task automatic t_rehunt();
        int l2;
        int idx;
        do_reset();
        send_byte(8'h55, 1'b1);
        send_frame(1'b1);
        send_byte(8'h11, 1'b1);
        send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b1);
        send_frame(1'b1);
        l2 = nb;
        send_byte(8'h22, 1'b1);
        send_byte(8'h33, 1'b1);
        chk(count_fp(0) == 2, "R6 second frame detected", count_fp(0), 2);
        idx = nth_fp(1);
        if (idx >= 0) begin
            chk(cap_t[idx] == l2 + 1, "R6 realign timing", cap_t[idx], l2 + 1);
            chk(idx + 1 < ncap && cap_t[idx+1] == l2 + 9, "R6 new byte spacing",
                (idx + 1 < ncap) ? cap_t[idx+1] : -1, l2 + 9);
        end
        check_bytes("R6 bytes after realign");
    endtask

    // R7 alignment frozen while oof low
    task automatic t_frozen();
        int l1;
        int idx;
        int off;
        do_reset();
        send_byte(8'h55, 1'b1);
        send_frame(1'b1);
        l1 = nb;
        send_byte(8'h11, 1'b1);
        send_byte(8'h22, 1'b0);
        for (int k = 0; k < 5; k++) send_bit(k[1], 1'b0);
        send_frame(1'b0);
        send_byte(8'h33, 1'b0);
        send_byte(8'h44, 1'b0);
        chk(count_fp(0) == 1, "R7 pattern ignored with oof low", count_fp(0), 1);
        idx = nth_fp(0);
        off = 0;
        if (idx >= 0) begin
            for (int i = idx; i < ncap; i++)
                if (((cap_t[i] - (l1 + 1)) % 8) != 0) off++;
        end
        chk(idx >= 0 && off == 0, "R7 byte boundary unchanged", off, 0);
        check_bytes("R7 bytes keep old boundary");
    endtask

    // R8 pending detection across oof fall
    task automatic t_pending();
        int last;
        int idx;
        do_reset();
        send_byte(8'h55, 1'b1);
        send_byte(A1, 1'b1); send_byte(A1, 1'b1); send_byte(A1, 1'b1);
        send_byte(A2, 1'b1);
        send_byte(A2, 1'b0); send_byte(A2, 1'b0);
        last = nb;
        send_byte(8'h11, 1'b0);
        send_byte(8'h22, 1'b0);
        chk(count_fp(0) == 1, "R8 pending frame completes", count_fp(0), 1);
        idx = nth_fp(0);
        if (idx >= 0) chk(cap_t[idx] == last + 1, "R8 pending frame timing", cap_t[idx], last + 1);
        do_reset();
        send_byte(8'h55, 1'b1);
        send_byte(A1, 1'b1); send_byte(A1, 1'b1);
        send_byte(A1, 1'b0);
        send_byte(A2, 1'b0); send_byte(A2, 1'b0); send_byte(A2, 1'b0);
        send_byte(8'h11, 1'b0);
        chk(count_fp(0) == 0, "R8 early oof drop gives no frame", count_fp(0), 0);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_offsets();
        t_near_miss();
        t_rehunt();
        t_frozen();
        t_pending();
        summary();
        $finish;
    end

endmodule